// File: doc/BRIEF.md
# Bus Breakpoint Trigger Unit

This block watches every transfer on a shared system bus and raises a debug trigger when a programmable condition holds. The condition is built from three sub-triggers. The first is an address sub-trigger made from two comparators. The second is a master-grant match against a per-master mask. The third is a signal-status match on the opcode, the privilege level and the read/write direction. A control word enables each sub-trigger and picks, bit by bit, whether it joins the others by AND or by OR.

Software programs five registers through a simple write port, then writes the rearm bit. Once armed, the unit fires exactly one single-cycle pulse on the first matching valid transfer. It then stays disarmed until the next rearm write. The armed state is visible on its own output, so a debugger can tell whether a breakpoint has already been consumed.

Top module: `bus_brkpt_unit`

## Requirements
- R1: After reset `armed_o` and `trig_o` are 0, and no transfer produces a trigger until a rearm write occurs.
- R2: A write with `cfg_we`=1 selects a register by `cfg_sel`: 0 address-1 reference, 1 address-2 reference, 2 control, 3 grant mask, 4 status pattern. The new value is used from the next cycle. The control word is laid out as follows: bits 31:28 hold the status-enable nibble, 25:24 the address-2 mode, 21:20 the address-1 mode, bit 16 the grant enable, 14:12 the join field, and bit 4 the rearm bit.
- R3: Each address comparator takes a 2-bit mode. 00 gives no address sub-trigger. 01 hits when the bus address is below the reference. 10 hits when it is greater than or equal to the reference. 11 hits when it is equal to the reference.
- R4: Join bit 1 set makes the address sub-trigger the AND of the two comparators; clear makes it their OR.
- R5: The grant mask holds one bit per master, indexed by `bus_mid`, and a 0 bit selects that master. The grant sub-trigger is active only when control bit 16 is 1. Join bit 0 set ANDs it with the address result; clear ORs it.
- R6: The status pattern register holds the opcode in bits 3:0, the privilege value in bit 4, the write value in bit 5 and the read value in bit 6. The status-enable nibble turns on comparison of each field: bit 0 the opcode, bit 1 privilege, bit 2 write, bit 3 read. With the nibble at 0000, the status sub-trigger hits on any opcode other than the no-operation code 4'hF. Join bit 2 set ANDs the status result with the address/grant result; clear ORs it.
- R7: A disabled address comparator or grant sub-trigger is replaced by the neutral value of its join: 1 for AND, 0 for OR. If both address comparators are disabled, the address term itself counts as disabled.
- R8: A matching transfer seen while armed drives `trig_o` high for exactly the following cycle and clears `armed_o` on the same edge. While disarmed, nothing triggers.
- R9: A control write with bit 4 set sets `armed_o` from the next cycle. This holds even if a transfer fires in the same cycle.
- R10: A cycle with `bus_valid`=0 never produces a trigger and never disarms the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A transfer is present this cycle |
| bus_addr | input | 32 | Transfer address |
| bus_mid | input | 3 | Master identifier of the transfer |
| bus_opc | input | 4 | Transfer opcode |
| bus_rd | input | 1 | Read transfer |
| bus_wr | input | 1 | Write transfer |
| bus_sv | input | 1 | Supervisor (privileged) transfer |
| trig_o | output | 1 | Single-cycle debug trigger |
| armed_o | output | 1 | Breakpoint logic is armed |

## Verification
The assertions treat `cfg_we`, `cfg_sel` and the rearm bit as the only way the unit can be armed. They also assume that `bus_valid` is meaningful on every clock after reset, so a trigger can always be traced to a valid transfer one cycle earlier. The stimulus meets these assumptions by changing every input only at the falling edge, never leaving an input undriven after reset, and arming the unit only through explicit control writes. Each scenario puts a rearm in its configuration sequence, so the pulse and disarm behaviour is observed from a known armed state.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  localparam logic [2:0] SEL_ADR1 = 3'd0;
  localparam logic [2:0] SEL_ADR2 = 3'd1;
  localparam logic [2:0] SEL_CTRL = 3'd2;
  localparam logic [2:0] SEL_GMSK = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;
  localparam int         REARM_BIT = 4;
  localparam logic [3:0] OPC_NOP  = 4'hF;

  typedef struct packed {
    logic [3:0] st_en;     // bit0 opc, bit1 priv, bit2 write, bit3 read
    logic [1:0] a2_mode;
    logic [1:0] a1_mode;
    logic       g_en;
    logic [2:0] join_sel;  // bit0 grant, bit1 address pair, bit2 status
  } ctrl_t;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       sv;
    logic [3:0] opc;
  } stat_t;

  // joins two optional terms; returns {enabled, value}
  function automatic logic [1:0] join2(input logic en_a, input logic a,
                                       input logic en_b, input logic b,
                                       input logic use_and);
    logic v;
    if (use_and) v = (!en_a || a) && (!en_b || b);
    else         v = (en_a && a) || (en_b && b);
    return {en_a || en_b, (en_a || en_b) && v};
  endfunction
endpackage

// File: rtl/bbt_cfg_regs.sv
module bbt_cfg_regs
  import bbt_pkg::*;
#(
  parameter int AW = 32,
  parameter int NM = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [AW-1:0] adr1_q,
  output logic [AW-1:0] adr2_q,
  output ctrl_t         ctrl_q,
  output logic [NM-1:0] gmsk_q,
  output stat_t         stat_q,
  output logic          rearm_wr
);
  logic [AW-1:0] adr1_d, adr2_d;
  ctrl_t         ctrl_d;
  logic [NM-1:0] gmsk_d;
  stat_t         stat_d;

  always_comb begin
    adr1_d = adr1_q;
    adr2_d = adr2_q;
    ctrl_d = ctrl_q;
    gmsk_d = gmsk_q;
    stat_d = stat_q;
    rearm_wr = 1'b0;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_ADR1: adr1_d = cfg_wdata[AW-1:0];
        SEL_ADR2: adr2_d = cfg_wdata[AW-1:0];
        SEL_CTRL: begin
          ctrl_d.st_en    = cfg_wdata[31:28];
          ctrl_d.a2_mode  = cfg_wdata[25:24];
          ctrl_d.a1_mode  = cfg_wdata[21:20];
          ctrl_d.g_en     = cfg_wdata[16];
          ctrl_d.join_sel = cfg_wdata[14:12];
          rearm_wr        = cfg_wdata[REARM_BIT];
        end
        SEL_GMSK: gmsk_d = cfg_wdata[NM-1:0];
        SEL_STAT: stat_d = cfg_wdata[6:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr1_q <= '0;
      adr2_q <= '0;
      ctrl_q <= '0;
      gmsk_q <= '1;
      stat_q <= '0;
    end else if (cfg_we) begin
      adr1_q <= adr1_d;
      adr2_q <= adr2_d;
      ctrl_q <= ctrl_d;
      gmsk_q <= gmsk_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/bbt_addr_cmp.sv
module bbt_addr_cmp #(
  parameter int AW = 32
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] bus_addr,
  output logic          en,
  output logic          hit
);
  always_comb begin
    en = (mode != 2'b00);
    unique case (mode)
      2'b01:   hit = bus_addr <  ref_addr;
      2'b10:   hit = bus_addr >= ref_addr;
      2'b11:   hit = bus_addr == ref_addr;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bbt_status_match.sv
module bbt_status_match
  import bbt_pkg::*;
(
  input  logic [3:0] st_en,
  input  stat_t      pat,
  input  logic [3:0] bus_opc,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic       bus_sv,
  output logic       hit
);
  logic opc_ok, sv_ok, wr_ok, rd_ok;

  always_comb begin
    opc_ok = !st_en[0] || (bus_opc == pat.opc);
    sv_ok  = !st_en[1] || (bus_sv  == pat.sv);
    wr_ok  = !st_en[2] || (bus_wr  == pat.wr);
    rd_ok  = !st_en[3] || (bus_rd  == pat.rd);
    if (st_en == 4'b0000) hit = (bus_opc != OPC_NOP);
    else                  hit = opc_ok && sv_ok && wr_ok && rd_ok;
  end
endmodule

// File: rtl/bus_brkpt_unit.sv
module bus_brkpt_unit
  import bbt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NM  = 8,
  parameter int DW  = 32,
  localparam int MIDW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic [MIDW-1:0] bus_mid,
  input  logic [3:0]      bus_opc,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic            bus_sv,
  output logic            trig_o,
  output logic            armed_o
);
  logic [AW-1:0] adr1_q, adr2_q;
  ctrl_t         ctrl_q;
  logic [NM-1:0] gmsk_q;
  stat_t         stat_q;
  logic          rearm_wr;

  bbt_cfg_regs #(.AW(AW), .NM(NM), .DW(DW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .adr1_q, .adr2_q, .ctrl_q, .gmsk_q, .stat_q, .rearm_wr
  );

  logic [1:0]    a_en, a_hit;
  logic [1:0]    a_mode [2];
  logic [AW-1:0] a_ref  [2];
  assign a_mode[0] = ctrl_q.a1_mode;
  assign a_mode[1] = ctrl_q.a2_mode;
  assign a_ref[0]  = adr1_q;
  assign a_ref[1]  = adr2_q;

  for (genvar i = 0; i < 2; i++) begin : g_cmp
    bbt_addr_cmp #(.AW(AW)) u_cmp (
      .mode(a_mode[i]), .ref_addr(a_ref[i]), .bus_addr,
      .en(a_en[i]), .hit(a_hit[i])
    );
  end

  logic st_hit;
  bbt_status_match u_stat (
    .st_en(ctrl_q.st_en), .pat(stat_q), .bus_opc, .bus_rd, .bus_wr, .bus_sv,
    .hit(st_hit)
  );

  logic       g_hit, match, fire;
  logic [1:0] addr_t, ag_t, all_t;
  logic       armed_d, trig_d, armed_q, trig_q;

  always_comb begin
    g_hit   = ctrl_q.g_en && !gmsk_q[bus_mid];
    addr_t  = join2(a_en[0], a_hit[0], a_en[1], a_hit[1], ctrl_q.join_sel[1]);
    ag_t    = join2(addr_t[1], addr_t[0], ctrl_q.g_en, g_hit, ctrl_q.join_sel[0]);
    all_t   = join2(ag_t[1], ag_t[0], 1'b1, st_hit, ctrl_q.join_sel[2]);
    match   = all_t[0];
    fire    = armed_q && bus_valid && match;
    trig_d  = fire;
    armed_d = rearm_wr ? 1'b1 : (fire ? 1'b0 : armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= trig_d;
    end
  end

  assign trig_o  = trig_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/bus_brkpt_unit_chk.sv
module bus_brkpt_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [DW-1:0] cfg_wdata,
  input logic          bus_valid,
  input logic          trig_o,
  input logic          armed_o
);
  logic rearm_req;
  assign rearm_req = cfg_we && (cfg_sel == 3'd2) && cfg_wdata[4];

  p_disarmed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |=> !trig_o);

  p_pulse_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !$past(rearm_req)) |-> !armed_o);

  p_rearm_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_req |=> armed_o);

  p_trig_from_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(bus_valid));

  p_disarm_only_by_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_o) |-> trig_o);
endmodule

bind bus_brkpt_unit bus_brkpt_unit_chk #(.DW(DW)) u_chk (
  .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .bus_valid, .trig_o, .armed_o
);

// File: tb/bus_brkpt_unit_bench.sv
module bus_brkpt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  bus_mid = '0;
  logic [3:0]  bus_opc = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_sv = 1'b0;
  logic        trig_o, armed_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bus_brkpt_unit u_bus_brkpt_unit (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .bus_valid, .bus_addr,
    .bus_mid, .bus_opc, .bus_rd, .bus_wr, .bus_sv, .trig_o, .armed_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [3:0] st, input logic [1:0] a2,
      input logic [1:0] a1, input logic g, input logic [2:0] j, input logic ra);
    return {st, 2'b00, a2, 2'b00, a1, 3'b000, g, 1'b0, j, 7'b0, ra, 4'b0};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one transfer, returns the trigger seen the following cycle
  task automatic xfer(input logic [31:0] a, input logic [2:0] m, input logic [3:0] o,
      input logic r, input logic w, input logic s, input logic v, output logic t);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_mid = m; bus_opc = o;
    bus_rd = r; bus_wr = w; bus_sv = s;
    @(negedge clk);
    bus_valid = 1'b0;
    t = trig_o;
  endtask

  task automatic rearm(input logic [31:0] c);
    wr(3'd2, c | 32'h10);
  endtask

  task automatic t_reset;
    logic t;
    chk("R1 armed after reset", armed_o, 1'b0);
    chk("R1 trig after reset", trig_o, 1'b0);
    xfer(32'h100, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R1 no trigger before rearm", t, 1'b0);
  endtask

  task automatic t_user_halfword;
    logic t;
    wr(3'd0, 32'h01FFFFFF);
    wr(3'd1, 32'h02FFFFFF);
    wr(3'd3, 32'hFFFFFFFF);
    wr(3'd4, 32'h00000001);
    rearm(mk_ctrl(4'b0011, 2'b10, 2'b10, 0, 3'b110, 1));
    chk("R9 armed after rearm", armed_o, 1'b1);
    xfer(32'h02000000, 3'd1, 4'h1, 1, 0, 0, 1, t);
    chk("R4 AND pair, only adr1 hit", t, 1'b0);
    xfer(32'h03000000, 3'd1, 4'h1, 1, 0, 1, 1, t);
    chk("R6 supervisor mismatch", t, 1'b0);
    xfer(32'h03000000, 3'd1, 4'h2, 0, 1, 0, 1, t);
    chk("R6 opcode mismatch", t, 1'b0);
    xfer(32'h03000000, 3'd1, 4'h1, 0, 1, 0, 0, t);
    chk("R10 valid low ignored", t, 1'b0);
    chk("R10 still armed", armed_o, 1'b1);
    xfer(32'h03000000, 3'd1, 4'h1, 0, 1, 0, 1, t);
    chk("R8 fires on match", t, 1'b1);
    chk("R8 disarmed after fire", armed_o, 1'b0);
    @(negedge clk);
    chk("R8 pulse one cycle", trig_o, 1'b0);
    xfer(32'h03000000, 3'd1, 4'h1, 1, 0, 0, 1, t);
    chk("R8 no second pulse", t, 1'b0);
  endtask

  task automatic t_addr_modes;
    logic t;
    wr(3'd0, 32'h00001000);
    wr(3'd1, 32'h00000800);
    // R3 mode 11 equal on adr1 only, status ANDed with nibble 0000
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b11, 0, 3'b110, 1));
    xfer(32'h00001004, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R3 equal mode miss", t, 1'b0);
    xfer(32'h00001000, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R3 equal mode hit", t, 1'b1);
    // R3 mode 01 below on adr2, R4 OR pair with adr1 disabled
    rearm(mk_ctrl(4'b0000, 2'b01, 2'b00, 0, 3'b100, 1));
    xfer(32'h00000900, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R3 below mode miss", t, 1'b0);
    xfer(32'h00000100, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R3 below mode hit / R7 OR neutral", t, 1'b1);
    // R4 OR pair: either comparator suffices
    rearm(mk_ctrl(4'b0000, 2'b01, 2'b11, 0, 3'b100, 1));
    xfer(32'h00001000, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R4 OR pair one hit", t, 1'b1);
    // R6 NOP opcode never hits status with nibble 0000
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b00, 0, 3'b100, 1));
    xfer(32'h00000000, 3'd0, 4'hF, 1, 0, 0, 1, t);
    chk("R6 NOP opcode ignored", t, 1'b0);
    xfer(32'h00000000, 3'd0, 4'h3, 1, 0, 0, 1, t);
    chk("R6 non-NOP hits", t, 1'b1);
  endtask

  task automatic t_grant;
    logic t;
    wr(3'd0, 32'hFFFF0000);
    wr(3'd3, 32'h000000F7);  // only master 3 selected
    // R5 grant ANDed with address (adr1 >= 0xFFFF0000), status ANDed
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b10, 1, 3'b101, 1));
    xfer(32'hFFFF0010, 3'd2, 4'h1, 1, 0, 0, 1, t);
    chk("R5 AND unselected master", t, 1'b0);
    xfer(32'hFFFF0010, 3'd3, 4'h1, 1, 0, 0, 1, t);
    chk("R5 AND selected master", t, 1'b1);
    // R5 grant ORed with address
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b10, 1, 3'b100, 1));
    xfer(32'h00000010, 3'd2, 4'h1, 1, 0, 0, 1, t);
    chk("R5 OR neither", t, 1'b0);
    xfer(32'h00000010, 3'd3, 4'h1, 1, 0, 0, 1, t);
    chk("R5 OR grant only", t, 1'b1);
    // R7 grant disabled under AND is neutral 1
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b10, 0, 3'b101, 1));
    xfer(32'hFFFF0010, 3'd2, 4'h1, 1, 0, 0, 1, t);
    chk("R7 disabled grant AND neutral", t, 1'b1);
  endtask

  task automatic t_status_dir;
    logic t;
    wr(3'd4, 32'h00000040);  // read value 1, write value 0
    // R7 address and grant off, OR join: status alone decides
    rearm(mk_ctrl(4'b1000, 2'b00, 2'b00, 0, 3'b000, 1));
    xfer(32'h0, 3'd0, 4'h1, 0, 1, 0, 1, t);
    chk("R6 read match rejects write", t, 1'b0);
    xfer(32'h0, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R6 read match accepts read", t, 1'b1);
  endtask

  task automatic t_rearm_race;
    logic t;
    rearm(mk_ctrl(4'b0000, 2'b00, 2'b00, 0, 3'b000, 1));
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd2;
    cfg_wdata = mk_ctrl(4'b0000, 2'b00, 2'b00, 0, 3'b000, 1);
    bus_valid = 1'b1; bus_addr = '0; bus_mid = '0; bus_opc = 4'h1;
    bus_rd = 1'b1; bus_wr = 1'b0; bus_sv = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0;
    chk("R9 fire with rearm pulses", trig_o, 1'b1);
    chk("R9 rearm wins over fire", armed_o, 1'b1);
    xfer(32'h0, 3'd0, 4'h1, 1, 0, 0, 1, t);
    chk("R9 fires again", t, 1'b1);
    // R2 unused select leaves registers intact
    wr(3'd7, 32'hFFFFFFFF);
    chk("R2 unused select no arm change", armed_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user_halfword();
    t_addr_modes();
    t_grant();
    t_status_dir();
    t_rearm_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule